// File: doc/BRIEF.md
# Run-Time Programmable CIC Rate Changer

This block is a cascaded integrator-comb filter that lowers or raises a sample rate. The whole datapath is built from adders, subtractors and registers, with no multipliers. One core serves both directions. In decimation it runs N integrators at the input rate, keeps one sample out of every R, and passes the kept samples through N comb sections. In interpolation it runs N comb sections at the input rate, follows each result with R-1 zero samples, and integrates the expanded stream at the output rate.

The stage count N (1 to 6), the rate factor R (2 to 64), the comb differential delay M (1 or 2) and the direction are all inputs that are sampled at run time. The core takes these values only on reset or on a synchronous clear, so they cannot change in the middle of a stream. Input samples arrive on a valid/ready handshake and output samples leave on a valid strobe. Every internal register is wide enough for the bit growth at the largest parameters. The integrators are allowed to wrap in two's complement, because the final result still comes out exact. The output is the wide result shifted right arithmetically and then truncated to the output width.

Top module: `cic_core`

## Requirements
- R1: In decimation mode, accepted inputs pass through N cascaded integrators. These update only on accepted samples, and each integrator's output already includes the current sample. The integrator result at every R-th accepted sample since the last clear goes through N comb stages. Each comb stage computes y = x - x delayed by M kept samples.
- R2: In interpolation mode, each accepted input passes through N comb stages that update at the input rate. The comb result feeds the integrator cascade in the same cycle, and R-1 zero samples follow it in the next R-1 cycles. One output is produced for each of those R cycles.
- R3: The output is bits [OUT_W-1:0] of the wide result shifted right arithmetically by S + IN_W - OUT_W. In decimation, S = N*ceil(log2(R*M)). In interpolation, S = N*ceil(log2(R*M)) - ceil(log2(R)).
- R4: Stages with an index above N are bypassed and pass their input through unchanged, so N=1 and N=6 both give the filter of exactly that order.
- R5: In decimation mode, in_ready is high in every cycle except a clear cycle. The output for the R-th accepted sample is valid in the cycle after the next clock edge following the edge that accepted that sample.
- R6: In interpolation mode, in_ready is high only when no expansion burst is in progress. The first output of a burst is valid right after the edge that accepts its input, and the remaining R-1 outputs follow in the next consecutive cycles.
- R7: The direction (cfg_interp: 0 decimate, 1 interpolate), N, R and M are captured only in a cycle with rst or clr high. Changes to them at any other time have no effect on the output.
- R8: A clr cycle zeroes every integrator, every comb delay register and the rate phase. It also drops out_valid on the next edge and holds in_ready low, so no input is accepted during clr.
- R9: At N=6, R=64, M=2, full-scale inputs of either sign give exact results, even though the integrators wrap internally.
- R10: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also captures the configuration |
| clr | input | 1 | Synchronous clear of the filter state; captures the configuration |
| cfg_interp | input | 1 | 0 selects decimation, 1 selects interpolation |
| cfg_stages | input | 3 | Stage count N, 1 to 6 |
| cfg_rate | input | 7 | Rate factor R, 2 to 64 |
| cfg_delay | input | 2 | Comb differential delay M, 1 or 2 |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Core accepts the sample in this cycle |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | Output sample present, one-cycle strobe |
| out_data | output | 16 | Signed output sample |

## Verification
The bench stamps every accepted input and every output strobe with a free-running cycle count. It samples all of them at the falling edge. Each decimated output must carry the stamp of the R-th accepted input plus one, and output k of an interpolation burst must carry the stamp of its input plus k. Output values are compared in order against a reference model in the bench, after a settling wait of R+6 cycles that lets the last burst or comb result appear. The effects of clear are checked half a cycle after the clear edge.

// File: rtl/cic_pkg.sv
package cic_pkg;

    localparam int CIC_IN_W  = 16;
    localparam int CIC_OUT_W = 16;
    localparam int CIC_N_MAX = 6;
    localparam int CIC_R_MAX = 64;
    localparam int CIC_M_MAX = 2;

    function automatic int ceil_log2(input int v);
        int r;
        r = 0;
        for (int i = 0; i < 31; i++) begin
            if ((32'sd1 <<< i) < v) r = i + 1;
        end
        return r;
    endfunction

    localparam int CIC_NS_W  = $clog2(CIC_N_MAX + 1);
    localparam int CIC_RT_W  = $clog2(CIC_R_MAX + 1);
    localparam int CIC_DL_W  = $clog2(CIC_M_MAX + 1);
    localparam int CIC_GROW  = CIC_N_MAX * ceil_log2(CIC_R_MAX * CIC_M_MAX);
    localparam int CIC_ACC_W = CIC_IN_W + CIC_GROW;
    localparam int CIC_SH_W  = $clog2(CIC_ACC_W + 1);

    typedef enum logic {
        MODE_DECIM  = 1'b0,
        MODE_INTERP = 1'b1
    } cic_mode_e;

    typedef struct packed {
        cic_mode_e             mode;
        logic [CIC_NS_W-1:0]   stages;
        logic [CIC_RT_W-1:0]   rate;
        logic [CIC_DL_W-1:0]   delay;
    } cic_cfg_t;

    typedef struct packed {
        logic in_acc;
        logic integ_en;
        logic integ_zero;
        logic comb_en;
        logic out_en;
    } cic_ctl_t;

    function automatic logic [CIC_SH_W-1:0] out_shift(input cic_cfg_t c);
        int g;
        g = int'(c.stages) * ceil_log2(int'(c.rate) * int'(c.delay));
        if (c.mode == MODE_INTERP) g = g - ceil_log2(int'(c.rate));
        return CIC_SH_W'(g + CIC_IN_W - CIC_OUT_W);
    endfunction

endpackage

// File: rtl/cic_integ_bank.sv
module cic_integ_bank #(
    parameter int ACC_W = 58,
    parameter int N_MAX = 6,
    parameter int NS_W  = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    en,
    input  logic [NS_W-1:0]         nst,
    input  logic signed [ACC_W-1:0] din,
    output logic signed [ACC_W-1:0] sum_out,
    output logic signed [ACC_W-1:0] last_q
);
    logic signed [ACC_W-1:0] chain   [N_MAX+1];
    logic signed [ACC_W-1:0] stage_q [N_MAX];

    assign chain[0] = din;

    for (genvar k = 0; k < N_MAX; k++) begin : g_stage
        logic signed [ACC_W-1:0] acc_q;
        assign chain[k+1] = (NS_W'(k) < nst) ? acc_q + chain[k] : chain[k];
        assign stage_q[k] = acc_q;
        always_ff @(posedge clk) begin
            if (rst || clr)  acc_q <= '0;
            else if (en)     acc_q <= chain[k+1];
        end
    end

    assign sum_out = chain[N_MAX];

    always_comb begin
        last_q = stage_q[0];
        for (int k = 0; k < N_MAX; k++) begin
            if (NS_W'(k + 1) == nst) last_q = stage_q[k];
        end
    end
endmodule

// File: rtl/cic_comb_bank.sv
module cic_comb_bank #(
    parameter int ACC_W = 58,
    parameter int N_MAX = 6,
    parameter int M_MAX = 2,
    parameter int NS_W  = 3,
    parameter int DL_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    en,
    input  logic [NS_W-1:0]         nst,
    input  logic [DL_W-1:0]         dly,
    input  logic signed [ACC_W-1:0] din,
    output logic signed [ACC_W-1:0] dout
);
    logic signed [ACC_W-1:0] chain [N_MAX+1];

    assign chain[0] = din;

    for (genvar k = 0; k < N_MAX; k++) begin : g_stage
        logic signed [ACC_W-1:0] line_q [M_MAX];
        logic signed [ACC_W-1:0] tap;

        always_comb begin
            tap = line_q[0];
            for (int j = 0; j < M_MAX; j++) begin
                if (DL_W'(j + 1) == dly) tap = line_q[j];
            end
        end

        assign chain[k+1] = (NS_W'(k) < nst) ? chain[k] - tap : chain[k];

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                for (int j = 0; j < M_MAX; j++) line_q[j] <= '0;
            end else if (en) begin
                line_q[0] <= chain[k];
                for (int j = 1; j < M_MAX; j++) line_q[j] <= line_q[j-1];
            end
        end
    end

    assign dout = chain[N_MAX];
endmodule

// File: rtl/cic_rate_ctrl.sv
module cic_rate_ctrl
    import cic_pkg::*;
#(
    parameter int RT_W = CIC_RT_W
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  cic_cfg_t cfg,
    input  logic     in_valid,
    output logic     in_ready,
    output cic_ctl_t ctl
);
    logic [RT_W-1:0] phase_q;
    logic            fire_q;
    logic            last_ph;
    logic            busy;
    logic            acc;
    logic            advance;
    logic            decim;

    assign decim    = (cfg.mode == MODE_DECIM);
    assign last_ph  = (phase_q == cfg.rate - RT_W'(1));
    assign busy     = (phase_q != '0);
    assign in_ready = !clr && (decim || !busy);
    assign acc      = in_valid && in_ready;
    assign advance  = decim ? acc : (acc || busy);

    always_comb begin
        ctl = '0;
        ctl.in_acc = acc;
        if (decim) begin
            ctl.integ_en = acc;
            ctl.comb_en  = fire_q;
            ctl.out_en   = fire_q;
        end else begin
            ctl.integ_en   = acc || busy;
            ctl.integ_zero = busy;
            ctl.comb_en    = acc;
            ctl.out_en     = acc || busy;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase_q <= '0;
            fire_q  <= 1'b0;
        end else begin
            fire_q <= decim && acc && last_ph;
            if (advance) phase_q <= last_ph ? '0 : phase_q + RT_W'(1);
        end
    end
endmodule

// File: rtl/cic_core.sv
module cic_core
    import cic_pkg::*;
#(
    parameter int IN_W  = CIC_IN_W,
    parameter int OUT_W = CIC_OUT_W,
    parameter int ACC_W = CIC_ACC_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    cfg_interp,
    input  logic [CIC_NS_W-1:0]     cfg_stages,
    input  logic [CIC_RT_W-1:0]     cfg_rate,
    input  logic [CIC_DL_W-1:0]     cfg_delay,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic signed [IN_W-1:0]  in_data,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_data
);
    cic_cfg_t cfg_in;
    cic_cfg_t cfg_q;
    cic_ctl_t ctl;

    logic signed [ACC_W-1:0] x_ext;
    logic signed [ACC_W-1:0] integ_din;
    logic signed [ACC_W-1:0] integ_sum;
    logic signed [ACC_W-1:0] integ_last;
    logic signed [ACC_W-1:0] comb_din;
    logic signed [ACC_W-1:0] comb_out;
    logic signed [ACC_W-1:0] result;
    logic [CIC_SH_W-1:0]     shamt;
    logic                    decim;

    assign cfg_in.mode   = cic_mode_e'(cfg_interp);
    assign cfg_in.stages = cfg_stages;
    assign cfg_in.rate   = cfg_rate;
    assign cfg_in.delay  = cfg_delay;

    // configuration is taken only while the filter state is being wiped
    always_ff @(posedge clk) begin
        if (rst || clr) cfg_q <= cfg_in;
    end

    assign decim = (cfg_q.mode == MODE_DECIM);
    assign x_ext = ACC_W'(in_data);

    cic_rate_ctrl u_rate (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .cfg      (cfg_q),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .ctl      (ctl)
    );

    // decimation: input -> integrators -> (register) -> combs
    // interpolation: input -> combs -> zero stuffing -> integrators
    assign integ_din = decim ? x_ext : (ctl.integ_zero ? '0 : comb_out);
    assign comb_din  = decim ? integ_last : x_ext;

    cic_integ_bank #(
        .ACC_W (ACC_W),
        .N_MAX (CIC_N_MAX),
        .NS_W  (CIC_NS_W)
    ) u_integ (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .en      (ctl.integ_en),
        .nst     (cfg_q.stages),
        .din     (integ_din),
        .sum_out (integ_sum),
        .last_q  (integ_last)
    );

    cic_comb_bank #(
        .ACC_W (ACC_W),
        .N_MAX (CIC_N_MAX),
        .M_MAX (CIC_M_MAX),
        .NS_W  (CIC_NS_W),
        .DL_W  (CIC_DL_W)
    ) u_comb (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr),
        .en   (ctl.comb_en),
        .nst  (cfg_q.stages),
        .dly  (cfg_q.delay),
        .din  (comb_din),
        .dout (comb_out)
    );

    assign result = decim ? comb_out : integ_sum;
    assign shamt  = out_shift(cfg_q);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= ctl.out_en;
            if (ctl.out_en) out_data <= OUT_W'(result >>> shamt);
        end
    end
endmodule

// File: rtl/cic_core_chk.sv
module cic_core_chk
    import cic_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     clr,
    input logic     in_valid,
    input logic     in_ready,
    input logic     out_valid,
    input cic_cfg_t cfg_q
);
    AST_CLR_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst)
        clr |-> !in_ready); // R8

    AST_CLR_DROPS_OUTPUT: assert property (@(posedge clk) disable iff (rst)
        clr |=> !out_valid); // R8

    AST_DECIM_ALWAYS_READY: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == MODE_DECIM && !clr) |-> in_ready); // R5

    AST_INTERP_READY_GAP: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == MODE_INTERP && in_valid && in_ready) |=> !in_ready); // R6

    AST_INTERP_OUT_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == MODE_INTERP && in_valid && in_ready) |=> out_valid); // R6

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
        !clr |=> $stable(cfg_q)); // R7
endmodule

bind cic_core cic_core_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .cfg_q     (cfg_q)
);

// File: tb/cic_core_tb.sv
module cic_core_tb;
    localparam int MW = 16 + 6 * 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clr = 1'b0;
    logic cfg_interp = 1'b0;
    logic [2:0] cfg_stages = 3'd1;
    logic [6:0] cfg_rate = 7'd2;
    logic [1:0] cfg_delay = 2'd1;
    logic in_valid = 1'b0;
    logic in_ready;
    logic signed [15:0] in_data = '0;
    logic out_valid;
    logic signed [15:0] out_data;

    int nchk = 0;
    int nerr = 0;
    int cyc = 0;
    int xs[$];
    int exp_d[$];
    int got_d[$];
    int got_t[$];
    int acc_t[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cic_core u_dut (
        .clk(clk), .rst(rst), .clr(clr),
        .cfg_interp(cfg_interp), .cfg_stages(cfg_stages),
        .cfg_rate(cfg_rate), .cfg_delay(cfg_delay),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            got_d.push_back(int'(out_data));
            got_t.push_back(cyc);
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic int lg(input int v);
        int r = 0;
        while ((1 << r) < v) r++;
        return r;
    endfunction

    function automatic int scale(input logic signed [MW-1:0] a, input int sh);
        logic signed [MW-1:0] s;
        s = a >>> sh;
        return int'($signed(s[15:0]));
    endfunction

    task automatic build_expected(input bit interp, input int n, input int r, input int m);
        logic signed [MW-1:0] ig[6];
        logic signed [MW-1:0] dl[6][2];
        logic signed [MW-1:0] v, c, t;
        int cnt, sh;
        cnt = 0;
        sh = n * lg(r * m) - (interp ? lg(r) : 0);
        for (int k = 0; k < 6; k++) begin
            ig[k] = '0; dl[k][0] = '0; dl[k][1] = '0;
        end
        exp_d.delete();
        foreach (xs[i]) begin
            if (!interp) begin
                v = MW'(xs[i]);
                for (int k = 0; k < n; k++) begin ig[k] = ig[k] + v; v = ig[k]; end
                cnt++;
                if (cnt == r) begin
                    cnt = 0;
                    c = ig[n-1];
                    for (int k = 0; k < n; k++) begin
                        t = c - dl[k][m-1];
                        dl[k][1] = dl[k][0]; dl[k][0] = c; c = t;
                    end
                    exp_d.push_back(scale(c, sh));
                end
            end else begin
                c = MW'(xs[i]);
                for (int k = 0; k < n; k++) begin
                    t = c - dl[k][m-1];
                    dl[k][1] = dl[k][0]; dl[k][0] = c; c = t;
                end
                for (int j = 0; j < r; j++) begin
                    v = (j == 0) ? c : '0;
                    for (int k = 0; k < n; k++) begin ig[k] = ig[k] + v; v = ig[k]; end
                    exp_d.push_back(scale(ig[n-1], sh));
                end
            end
        end
    endtask

    // pattern: 0 random, 1 +max, 2 -max, 3 impulse, 4 alternating full scale
    task automatic run_case(input bit interp, input int n, input int r, input int m,
                            input int ns, input int pat, input bit gaps,
                            input bit twid, input string vreq);
        logic [15:0] u;
        int lim;
        xs.delete();
        for (int i = 0; i < ns; i++) begin
            case (pat)
                0: begin u = 16'($urandom); xs.push_back(int'($signed(u))); end
                1: xs.push_back(32767);
                2: xs.push_back(-32768);
                3: xs.push_back(i == 0 ? 1000 : 0);
                default: xs.push_back((i % 2 == 0) ? 32767 : -32768);
            endcase
        end
        build_expected(interp, n, r, m);

        @(negedge clk);
        cfg_interp = interp; cfg_stages = 3'(n); cfg_rate = 7'(r); cfg_delay = 2'(m);
        clr = 1'b1; in_valid = 1'b1;
        #1;
        chk(in_ready == 1'b0, "R8", "in_ready during clear", in_ready, 0);
        @(negedge clk);
        clr = 1'b0; in_valid = 1'b0;
        chk(out_valid == 1'b0, "R8", "out_valid after clear", out_valid, 0);
        got_d.delete(); got_t.delete(); acc_t.delete();

        foreach (xs[i]) begin
            bit done = 1'b0;
            while (!done) begin
                bit v;
                @(negedge clk);
                v = gaps ? ($urandom % 4 != 0) : 1'b1;
                in_valid = v;
                in_data = 16'(xs[i]);
                if (twid) begin
                    cfg_interp = 1'($urandom); cfg_stages = 3'(1 + $urandom % 6);
                    cfg_rate = 7'(2 + $urandom % 63); cfg_delay = 2'(1 + $urandom % 2);
                end
                #1;
                if (v && in_ready) begin
                    done = 1'b1;
                    acc_t.push_back(cyc + 1);
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (r + 6) @(negedge clk);

        chk(got_d.size() == exp_d.size(), interp ? "R6" : "R5", "output count",
            got_d.size(), exp_d.size());
        lim = (got_d.size() < exp_d.size()) ? got_d.size() : exp_d.size();
        for (int i = 0; i < lim; i++) begin
            chk(got_d[i] == exp_d[i], vreq, "output value", got_d[i], exp_d[i]);
            if (!interp)
                chk(got_t[i] == acc_t[(i + 1) * r - 1] + 1, "R5", "decimated output cycle",
                    got_t[i], acc_t[(i + 1) * r - 1] + 1);
            else
                chk(got_t[i] == acc_t[i / r] + i % r, "R6", "burst output cycle",
                    got_t[i], acc_t[i / r] + i % r);
        end
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);
        chk(in_ready == 1'b1, "R10", "in_ready after reset", in_ready, 1);

        run_case(1'b0, 3, 8, 1, 64, 0, 1'b1, 1'b0, "R1");
        run_case(1'b0, 6, 64, 2, 640, 1, 1'b0, 1'b0, "R9");
        run_case(1'b0, 6, 64, 2, 640, 2, 1'b1, 1'b0, "R9");
        run_case(1'b0, 1, 2, 1, 40, 0, 1'b0, 1'b0, "R4");
        run_case(1'b0, 4, 5, 2, 53, 4, 1'b1, 1'b0, "R3");
        run_case(1'b1, 2, 4, 1, 40, 0, 1'b1, 1'b0, "R2");
        run_case(1'b1, 6, 64, 2, 12, 1, 1'b0, 1'b0, "R9");
        run_case(1'b1, 1, 3, 2, 10, 3, 1'b1, 1'b0, "R4");
        run_case(1'b1, 5, 7, 1, 30, 0, 1'b0, 1'b0, "R3");
        run_case(1'b0, 3, 16, 2, 160, 0, 1'b1, 1'b1, "R7");
        run_case(1'b1, 3, 4, 2, 30, 0, 1'b1, 1'b1, "R7");
        run_case(1'b0, 2, 3, 1, 31, 0, 1'b0, 1'b0, "R8");

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule